// File: doc/BRIEF.md
# Card Bus Clock Divider

This block derives the card bus clock from a reference clock through two cascaded stages. The first is an optional prescaler that divides by twice its setting. The second is a small integer stage that divides by one more than its setting. Software packs both settings into a single rate word and uses a control word to start or stop the output or to reset the block. A running flag shows whether the output is toggling.

A new rate word is held in a shadow register. It takes effect only where one output period ends and the next begins. Start and stop requests are applied only where the output is low. The output therefore never shows a shortened high or low phase, except after a soft reset, which acts at once. With a prescaler the output has an exact 50% duty cycle. In bypass mode the high phase is half the period, rounded down.

Top module: `card_clk_div`

## Requirements
- R1: After rst_ni is released, card_clk_o and running_o are low and the rate word is zero. A start with no rate write then gives a period of 2 reference cycles with 1 cycle high.
- R2: The rate word holds the integer setting d in bits [3:0] and the prescaler setting p in bits [15:4]. The output period is (d+1) reference cycles when p is 0 and (d+1)*2*p cycles otherwise. A d of 0 acts as 1.
- R3: When p is nonzero the high phase lasts exactly half the period. When p is 0 it lasts floor((d+1)/2) cycles, and the remaining cycles are low.
- R4: A control write with bit 1 set (bits 0 and 3 clear) while stopped sets running_o in the cycle after the write is sampled. card_clk_o rises one cycle later and begins with a full high phase.
- R5: A control write with bit 0 set while running lets the current period finish, including its whole low phase. running_o falls one reference cycle before the next rising edge would have occurred, and card_clk_o then stays low. Bit 0 takes priority over bit 1 when both are set in the same write.
- R6: A start written while a stop is still pending cancels that stop, and the clock keeps running with an unchanged period.
- R7: A control write with bit 3 set clears running_o and card_clk_o in the next cycle, whatever bits 0 and 1 hold. The rate word is kept, so a later start uses it.
- R8: A rate write while running leaves the period in progress unchanged, and the next period uses the new rate. A rate write sampled at the edge one cycle before a rising edge of card_clk_o already applies to the period that starts at that rising edge.
- R9: A rate write while stopped has no visible effect until the next start, and that start uses the new rate.
- R10: Bit 2 of the control word has no effect. Whether the clock is stopped or running, the state and the period are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_we_i | input | 1 | Rate word write strobe |
| rate_i | input | 16 | Rate word: d in [3:0], p in [15:4] |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_i | input | 4 | Control word: bit 0 stop, bit 1 start, bit 3 soft reset |
| card_clk_o | output | 1 | Card bus clock |
| running_o | output | 1 | High while the card bus clock runs |

## Verification
Two events can fall in the same cycle: a rate write and the end of a period. The bench measures the edge spacing of the running output and places the rate strobe exactly on the boundary edge, one cycle before the predicted rising edge. It expects the following period to use the new ratio already. It then repeats the write one cycle later and expects one more period at the old ratio. A second collision sends a stop and a start in one control word, and then a start while a stop is still waiting. The bench judges each case by whether running_o falls and by the measured period.

// File: rtl/ccd_pkg.sv
package ccd_pkg;
  localparam int unsigned DEF_DIV_W = 4;
  localparam int unsigned DEF_PRE_W = 12;
  localparam int unsigned CTL_W     = 4;
  localparam int unsigned CTL_STOP  = 0;
  localparam int unsigned CTL_START = 1;
  localparam int unsigned CTL_SRST  = 3;
endpackage

// File: rtl/ccd_prescaler.sv
module ccd_prescaler #(
  parameter int unsigned PRE_BITS = 12
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic [PRE_BITS-1:0] pre_i,
  output logic                tick_o
);
  logic [PRE_BITS-1:0] cnt_q;

  // p == 0: tick every cycle; else tick every p cycles (toggle stage doubles it)
  assign tick_o = (pre_i == '0) || (cnt_q == pre_i - PRE_BITS'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (clr_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + PRE_BITS'(1);
  end
endmodule

// File: rtl/ccd_divider.sv
module ccd_divider #(
  parameter int unsigned DIV_BITS = 4,
  localparam int unsigned CNT_W   = DIV_BITS + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                tick_i,
  input  logic                bypass_i,
  input  logic [DIV_BITS-1:0] div_i,
  output logic                phase_hi_o,
  output logic                wrap_o
);
  logic [DIV_BITS-1:0] d_eff;
  logic [CNT_W-1:0]    len, half, cnt_q;

  assign d_eff = (div_i == '0) ? DIV_BITS'(1) : div_i;

  // bypass: one phase cycle per tick; prescaled: two half-periods of (d+1) ticks
  always_comb begin
    len = CNT_W'(d_eff) + CNT_W'(1);
    if (!bypass_i) len = len << 1;
    half = len >> 1;
  end

  assign wrap_o     = tick_i && (cnt_q == len - CNT_W'(1));
  assign phase_hi_o = cnt_q < half;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || wrap_o) cnt_q <= '0;
    else if (tick_i)          cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/ccd_run_ctl.sv
module ccd_run_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic srst_i,
  input  logic wrap_i,
  output logic run_o
);
  logic run_q, pend_q, pend_eff;

  // stop beats start; a lone start drops a waiting stop
  assign pend_eff = stop_i || (pend_q && !start_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (srst_i) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (!run_q) begin
      run_q  <= start_i && !stop_i;
      pend_q <= 1'b0;
    end else if (wrap_i && pend_eff) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_eff;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
  import ccd_pkg::*;
#(
  parameter int unsigned DIV_BITS = DEF_DIV_W,
  parameter int unsigned PRE_BITS = DEF_PRE_W,
  localparam int unsigned RATE_W  = DIV_BITS + PRE_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rate_we_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              ctrl_we_i,
  input  logic [CTL_W-1:0]  ctrl_i,
  output logic              card_clk_o,
  output logic              running_o
);
  logic start, stop, srst, run, wrap, tick, phase_hi, clr, clk_q;
  logic [RATE_W-1:0]   pend_q, act_q, rate_nxt;
  logic [DIV_BITS-1:0] act_div;
  logic [PRE_BITS-1:0] act_pre;

  assign start = ctrl_we_i && ctrl_i[CTL_START];
  assign stop  = ctrl_we_i && ctrl_i[CTL_STOP];
  assign srst  = ctrl_we_i && ctrl_i[CTL_SRST];

  assign act_div  = act_q[DIV_BITS-1:0];
  assign act_pre  = act_q[RATE_W-1:DIV_BITS];
  assign rate_nxt = rate_we_i ? rate_i : pend_q;
  assign clr      = !run || srst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else if (rate_we_i) pend_q <= rate_i;
  end

  // active setting follows shadow while stopped, else only at period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else if (!run || wrap) act_q <= rate_nxt;
  end

  ccd_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .pre_i  (act_pre),
    .tick_o (tick)
  );

  ccd_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .tick_i     (tick),
    .bypass_i   (act_pre == '0),
    .div_i      (act_div),
    .phase_hi_o (phase_hi),
    .wrap_o     (wrap)
  );

  ccd_run_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .stop_i  (stop),
    .srst_i  (srst),
    .wrap_i  (wrap),
    .run_o   (run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_q <= 1'b0;
    else         clk_q <= run && phase_hi && !srst;
  end

  assign card_clk_o = clk_q;
  assign running_o  = run;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk
  import ccd_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [CTL_W-1:0] ctrl_i,
  input logic             card_clk_o,
  input logic             running_o
);
  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !card_clk_o); // R5

  AST_SRST_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_i[CTL_SRST] |=> !running_o && !card_clk_o); // R7

  AST_START_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && ctrl_we_i && ctrl_i[CTL_START] && !ctrl_i[CTL_STOP] && !ctrl_i[CTL_SRST]
    |=> running_o); // R4

  AST_RISE_AFTER_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_clk_o) |-> $past(running_o)); // R4

  AST_BIT2_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && ctrl_we_i && (ctrl_i == 4'b0100) |=> !running_o); // R10
endmodule

bind card_clk_div card_clk_div_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_we_i  (ctrl_we_i),
  .ctrl_i     (ctrl_i),
  .card_clk_o (card_clk_o),
  .running_o  (running_o)
);

// File: tb/sim_card_clk_div.sv
module sim_card_clk_div;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rate_we = 1'b0;
  logic [15:0] rate = '0;
  logic        ctrl_we = 1'b0;
  logic [3:0]  ctrl = '0;
  logic        card_clk, running;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_rise = 0;
  int last_per = 0;
  int last_hi = 0;
  int rises = 0;
  logic prev = 1'b0;

  always #4 clk = ~clk;

  card_clk_div u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rate_we_i  (rate_we),
    .rate_i     (rate),
    .ctrl_we_i  (ctrl_we),
    .ctrl_i     (ctrl),
    .card_clk_o (card_clk),
    .running_o  (running)
  );

  // edge monitor on the output, one sample per reference cycle
  always @(negedge clk) begin
    cyc++;
    if (card_clk && !prev) begin
      rises++;
      last_per  = cyc - last_rise;
      last_rise = cyc;
    end
    if (!card_clk && prev) last_hi = cyc - last_rise;
    prev = card_clk;
    if (cyc == 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ctrl_wr(logic [3:0] v);
    ctrl = v;
    ctrl_we = 1'b1;
    tick();
    ctrl_we = 1'b0;
    ctrl = '0;
  endtask

  task automatic rate_wr(int d, int p);
    rate = 16'((p << 4) | d);
    rate_we = 1'b1;
    tick();
    rate_we = 1'b0;
  endtask

  task automatic wait_rises(int n);
    int tgt;
    int g;
    tgt = rises + n;
    g = 0;
    while (rises < tgt && g < 20000) begin
      tick();
      g++;
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic stop_wait();
    int g;
    ctrl_wr(4'b0001);
    g = 0;
    while (running && g < 20000) begin
      tick();
      g++;
    end
  endtask

  function automatic int exp_per(int d, int p);
    int de;
    de = (d == 0) ? 1 : d;
    return (de + 1) * ((p == 0) ? 1 : 2 * p);
  endfunction

  function automatic int exp_hi(int d, int p);
    int de;
    de = (d == 0) ? 1 : d;
    return (p == 0) ? (de + 1) / 2 : p * (de + 1);
  endfunction

  // stopped -> program -> start -> measure first period -> stop
  task automatic run_cfg(int d, int p);
    rate_wr(d, p);
    ctrl_wr(4'b0010);
    chk_eq("R4 running after start", int'(running), 1);
    chk_eq("R4 clock low first cycle", int'(card_clk), 0);
    tick();
    chk_eq("R4 clock rises", int'(card_clk), 1);
    wait_rises(1);
    chk_eq("R2 R9 period", last_per, exp_per(d, p));
    chk_eq("R3 high phase", last_hi, exp_hi(d, p));
    stop_wait();
    chk_eq("R5 stopped", int'(running), 0);
  endtask

  initial begin
    int r0;
    int g;
    ticks(3);
    rst_n = 1'b1;
    tick();
    chk_eq("R1 clock low", int'(card_clk), 0);
    chk_eq("R1 not running", int'(running), 0);
    ctrl_wr(4'b0010);
    tick();
    wait_rises(1);
    chk_eq("R1 default period", last_per, 2);
    chk_eq("R1 default high", last_hi, 1);
    stop_wait();

    // sweep
    for (int pi = 0; pi < 4; pi++) begin
      for (int d = 0; d < 16; d++) begin
        int p;
        p = (pi == 0) ? 0 : (1 << (pi - 1));
        run_cfg(d, p);
      end
    end
    run_cfg(1, 2048);

    // R5: stop during high phase, d=3 p=0 -> period 4, high 2
    rate_wr(3, 0);
    ctrl_wr(4'b0010);
    wait_rises(2);
    r0 = rises;
    ctrl_wr(4'b0001);
    g = 0;
    while (running && g < 100) begin
      tick();
      g++;
    end
    chk_eq("R5 running falls at end of low phase", g, 2);
    ticks(12);
    chk_eq("R5 no rise after stop", rises, r0);
    chk_eq("R5 last high phase complete", last_hi, 2);
    chk_eq("R5 clock stays low", int'(card_clk), 0);

    // R5: stop and start in one write -> stop wins
    ctrl_wr(4'b0010);
    wait_rises(2);
    ctrl_wr(4'b0011);
    ticks(12);
    chk_eq("R5 stop beats start", int'(running), 0);

    // R6: start cancels pending stop, d=7 p=0 -> period 8
    rate_wr(7, 0);
    ctrl_wr(4'b0010);
    wait_rises(2);
    ctrl_wr(4'b0001);
    ctrl_wr(4'b0010);
    r0 = rises;
    ticks(24);
    chk_eq("R6 still running", int'(running), 1);
    chk_eq("R6 rises continue", int'(rises >= r0 + 2), 1);
    wait_rises(1);
    chk_eq("R6 period unchanged", last_per, 8);

    // R8: mid-period rate change, A = d3 p0 (4), B = d5 p1 (12, high 6)
    stop_wait();
    rate_wr(3, 0);
    ctrl_wr(4'b0010);
    wait_rises(2);
    rate_wr(5, 1);
    wait_rises(1);
    chk_eq("R8 period in progress keeps old ratio", last_per, 4);
    wait_rises(1);
    chk_eq("R8 new period", last_per, 12);
    chk_eq("R8 new high", last_hi, 6);

    // R8 collision: A = d7 p0 (8), B = d2 p0 (3); write at boundary edge
    stop_wait();
    rate_wr(7, 0);
    ctrl_wr(4'b0010);
    wait_rises(2);
    ticks(6);
    rate_wr(2, 0);
    wait_rises(1);
    chk_eq("R8 boundary: finishing period", last_per, 8);
    wait_rises(1);
    chk_eq("R8 boundary write applies at once", last_per, 3);

    // R8 one cycle later: one more old period
    stop_wait();
    rate_wr(7, 0);
    ctrl_wr(4'b0010);
    wait_rises(2);
    ticks(7);
    rate_wr(2, 0);
    wait_rises(1);
    chk_eq("R8 late write keeps old period", last_per, 8);
    wait_rises(1);
    chk_eq("R8 late write applies next", last_per, 3);

    // R7: soft reset with start bit during high phase, rate kept (d7 p0)
    stop_wait();
    rate_wr(7, 0);
    ctrl_wr(4'b0010);
    wait_rises(2);
    ctrl_wr(4'b1010);
    chk_eq("R7 running cleared", int'(running), 0);
    chk_eq("R7 clock cleared", int'(card_clk), 0);
    r0 = rises;
    ticks(24);
    chk_eq("R7 no rise after reset", rises, r0);
    ctrl_wr(4'b0010);
    wait_rises(2);
    chk_eq("R7 rate kept", last_per, 8);

    // R10: bit 2 ignored while running and while stopped
    ctrl_wr(4'b0100);
    wait_rises(2);
    chk_eq("R10 running unaffected", int'(running), 1);
    chk_eq("R10 period unaffected", last_per, 8);
    stop_wait();
    r0 = rises;
    ctrl_wr(4'b0100);
    ticks(10);
    chk_eq("R10 stopped unaffected", int'(running), 0);
    chk_eq("R10 no clock while stopped", rises, r0);

    // R9: rate write while stopped is invisible until start
    rate_wr(4, 2);
    ticks(10);
    chk_eq("R9 no clock after rate write", rises, r0);
    ctrl_wr(4'b0010);
    wait_rises(2);
    chk_eq("R9 new rate on start", last_per, exp_per(4, 2));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule